// File: doc/BRIEF.md
# Baseband Register Access Port

This block lets a host bus reach the internal registers of an external baseband chip through a small window of four 16-bit locations. The locations are a command location, a write-data location, a read-data location and a status location. The host first loads the write-data location when it needs to. It then writes one command word. The top nibble of that word is an opcode that picks read or write, and the low bits carry the register number.

An accepted command starts a 16-bit serial frame on a four-wire link: a clock, an active-low select, data out and data in. The frame carries a read/write flag, a 7-bit register number and 8 data bits, most significant bit first. When a read frame finishes, the byte captured from the chip goes into the read-data location. Bit 0 of the status location shows that a frame is in flight. The host polls it low before it issues the next command.

Top module: `bbp_access_port`

## Requirements
- R1: After reset the status location reads 0, the read-data location reads 0, `bb_csn` is high and `bb_sclk` is low.
- R2: Writing location 0 with bits [15:12] = 4'h5 sends the frame {1'b0, word[6:0], wdata[7:0]}, and the chip's register takes the low byte of the write-data location.
- R3: Writing location 0 with bits [15:12] = 4'h6 sends the frame {1'b1, word[6:0], 8 bits}. When the frame ends, location 2 reads {8'h00, the 8 bits sampled on `bb_miso` at the last eight rising clocks}.
- R4: Location 1 holds the value last written to it and reads it back. It is the data source for write frames.
- R5: Status bit 0 reads 1 from the clock edge that accepts a command. It stays 1 for exactly 32*CLK_DIV system cycles and then returns to 0.
- R6: A command written while status bit 0 is 1 is ignored. No new frame follows it, and location 0 keeps reading the last accepted command.
- R7: A command word whose opcode is neither 4'h5 nor 4'h6 starts nothing and leaves busy at 0.
- R8: During a frame `bb_csn` is low and `bb_sclk` gives exactly 16 rising edges with a period of 2*CLK_DIV system cycles. Data changes on falling edges and is sampled on rising edges. Between frames `bb_sclk` is low.
- R9: Location 2 changes only when a read frame completes. Write frames and host writes leave it unchanged.
- R10: Bit 7 of the command's low byte is ignored, so register numbers 0 through 0x7F are reachable (0x00FF addresses 0x7F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Location select: 0 command, 1 write data, 2 read data, 3 status |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the selected location (combinational) |
| bb_sclk | output | 1 | Serial clock to the baseband chip |
| bb_csn | output | 1 | Active-low chip select |
| bb_mosi | output | 1 | Serial data to the chip |
| bb_miso | input | 1 | Serial data from the chip |

## Verification
The bench issues a command while a frame is in flight. A design that did not gate on busy would restart the shifter and corrupt the frame, or latch a second command word. It measures the busy window to the cycle and the serial clock period, which exposes an off-by-one divider or a frame that drops or adds a bit. It also sends reserved opcodes, checks that a write frame leaves the read-data location alone, and uses register 0x7F, reached through a low byte with bit 7 set. Each of these catches a decoder that is too loose or a result register that loads on the wrong event.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
  localparam int HOST_W  = 16;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int OP_W    = 4;
  localparam logic [OP_W-1:0] OP_WRITE = 4'h5;
  localparam logic [OP_W-1:0] OP_READ  = 4'h6;

  typedef enum logic [1:0] {
    LOC_CMD    = 2'd0,
    LOC_WDATA  = 2'd1,
    LOC_RDATA  = 2'd2,
    LOC_STATUS = 2'd3
  } loc_e;

  typedef struct packed {
    logic              valid;
    logic              is_read;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [HOST_W-1:0] word);
    cmd_t c;
    logic [OP_W-1:0] op;
    op        = word[HOST_W-1 -: OP_W];
    c.valid   = (op == OP_WRITE) || (op == OP_READ);
    c.is_read = (op == OP_READ);
    c.addr    = word[ADDR_W-1:0];
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic is_read,
                                                     input logic [ADDR_W-1:0] addr,
                                                     input logic [DATA_W-1:0] data);
    return {is_read, addr, data};
  endfunction
endpackage

// File: rtl/bbp_clk_div.sv
module bbp_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF - 1);

  logic [DIV_W-1:0] cnt_q;

  assign half_tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bbp_host_regs.sv
module bbp_host_regs
  import bbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              accept,
  output logic              acc_is_read,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] wr_byte,
  output logic [HOST_W-1:0] rd_data
);
  loc_e              sel;
  cmd_t              dec;
  logic              cmd_wr;
  logic [HOST_W-1:0] cmd_q;
  logic [HOST_W-1:0] wdata_q;
  logic [HOST_W-1:0] rdata_q;

  assign sel         = loc_e'(host_addr);
  assign dec         = decode_cmd(host_wdata);
  assign cmd_wr      = host_wr && (sel == LOC_CMD);
  assign accept      = cmd_wr && dec.valid && !busy;
  assign acc_is_read = dec.is_read;
  assign acc_addr    = dec.addr;
  assign wr_byte     = wdata_q[DATA_W-1:0];
  assign rd_data     = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (host_wr && (sel == LOC_WDATA)) wdata_q <= host_wdata;
      if (accept)  cmd_q   <= host_wdata;
      if (rd_load) rdata_q <= {{(HOST_W-DATA_W){1'b0}}, rd_byte};
    end
  end

  always_comb begin
    unique case (sel)
      LOC_CMD:    host_rdata = cmd_q;
      LOC_WDATA:  host_rdata = wdata_q;
      LOC_RDATA:  host_rdata = rdata_q;
      default:    host_rdata = {{(HOST_W-1){1'b0}}, busy};
    endcase
  end
endmodule

// File: rtl/bbp_serial_engine.sv
module bbp_serial_engine
  import bbp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_is_read,
  input  logic [FRAME_W-1:0] frame,
  input  logic               half_tick,
  input  logic               miso,
  output logic               sclk,
  output logic               csn,
  output logic               mosi,
  output logic               busy,
  output logic               xfer_done,
  output logic               rd_load,
  output logic [DATA_W-1:0]  rx_byte
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               busy_q, sclk_q, csn_q, read_q;
  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;
  logic [CNT_W-1:0]   bit_q;
  logic               rise_ev, fall_ev;

  assign rise_ev   = busy_q && half_tick && !sclk_q;
  assign fall_ev   = busy_q && half_tick &&  sclk_q;
  assign xfer_done = fall_ev && (bit_q == LAST_BIT);
  assign rd_load   = xfer_done && read_q;
  assign rx_byte   = rx_q;
  assign sclk      = sclk_q;
  assign csn       = csn_q;
  assign busy      = busy_q;
  assign mosi      = tx_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      read_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      csn_q  <= 1'b0;
      sclk_q <= 1'b0;
      read_q <= start_is_read;
      tx_q   <= frame;
      bit_q  <= '0;
    end else if (rise_ev) begin
      sclk_q <= 1'b1;
      rx_q   <= {rx_q[DATA_W-2:0], miso};
    end else if (fall_ev) begin
      sclk_q <= 1'b0;
      tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
      if (bit_q == LAST_BIT) begin
        busy_q <= 1'b0;
        csn_q  <= 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bbp_access_port.sv
module bbp_access_port
  import bbp_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        bb_sclk,
  output logic        bb_csn,
  output logic        bb_mosi,
  input  logic        bb_miso
);
  logic               accept, acc_is_read;
  logic [ADDR_W-1:0]  acc_addr;
  logic [DATA_W-1:0]  wr_byte, rx_byte;
  logic [FRAME_W-1:0] frame;
  logic               busy, half_tick, xfer_done, rd_load;
  logic [HOST_W-1:0]  rd_data;

  assign frame = build_frame(acc_is_read, acc_addr, wr_byte);

  bbp_host_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .busy        (busy),
    .rd_load     (rd_load),
    .rd_byte     (rx_byte),
    .accept      (accept),
    .acc_is_read (acc_is_read),
    .acc_addr    (acc_addr),
    .wr_byte     (wr_byte),
    .rd_data     (rd_data)
  );

  bbp_clk_div #(.HALF(CLK_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .half_tick (half_tick)
  );

  bbp_serial_engine u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .start_is_read (acc_is_read),
    .frame         (frame),
    .half_tick     (half_tick),
    .miso          (bb_miso),
    .sclk          (bb_sclk),
    .csn           (bb_csn),
    .mosi          (bb_mosi),
    .busy          (busy),
    .xfer_done     (xfer_done),
    .rd_load       (rd_load),
    .rx_byte       (rx_byte)
  );
endmodule

// File: rtl/bbp_access_port_sva.sv
module bbp_access_port_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        busy,
  input logic        xfer_done,
  input logic        rd_load,
  input logic        half_tick,
  input logic        sclk,
  input logic        csn,
  input logic [15:0] rd_data
);
  // R5: an accepted command raises busy on the next cycle
  p_busy_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R6: a frame in flight is never cut short
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> (busy && !csn));

  // R8: select is low exactly while busy
  p_csn_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !csn);

  // R8: idle link keeps the clock low and select high
  p_idle_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csn && !sclk));

  // R8: serial clock only moves on a divider tick
  p_sclk_paced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !half_tick && !accept) |=> $stable(sclk));

  // R9: read-data location holds unless a read completes
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(rd_data));

  // R3: loaded read data is zero-extended
  p_rdata_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (rd_data[15:8] == 8'h00));

  // R8: a frame ends on a falling serial edge
  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> sclk);
endmodule

bind bbp_access_port bbp_access_port_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .busy      (busy),
  .xfer_done (xfer_done),
  .rd_load   (rd_load),
  .half_tick (half_tick),
  .sclk      (bb_sclk),
  .csn       (bb_csn),
  .rd_data   (rd_data)
);

// File: tb/bbp_access_port_test.sv
`timescale 1ns/1ps
module bbp_access_port_test;
  localparam int CLK_DIV = 2;
  localparam int XFER_CYC = 32 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        bb_sclk, bb_csn, bb_mosi;
  logic        bb_miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bbp_access_port #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bb_sclk(bb_sclk),
    .bb_csn(bb_csn), .bb_mosi(bb_mosi), .bb_miso(bb_miso)
  );

  // ---- baseband chip model ----
  logic [7:0]  smem [0:127];
  logic [15:0] sh = 16'h0;
  int          scnt = 0;
  int          frames = 0;
  logic [15:0] last_frame = 16'h0;
  int          rises = 0;
  int          cyc = 0;
  int          last_rise = 0;
  int          last_period = 0;
  logic        s_rw = 1'b0;
  logic [6:0]  s_addr = 7'h0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge bb_sclk or posedge bb_csn) begin
    if (bb_csn) begin
      if (scnt == 16) begin
        frames     <= frames + 1;
        last_frame <= sh;
        if (!sh[15]) smem[sh[14:8]] <= sh[7:0];
      end
      scnt <= 0;
    end else begin
      sh    <= {sh[14:0], bb_mosi};
      scnt  <= scnt + 1;
      rises <= rises + 1;
      if (scnt > 0) last_period <= cyc - last_rise;
      last_rise <= cyc;
    end
  end

  always @(negedge bb_sclk) begin
    if (!bb_csn) begin
      if (scnt == 8) begin
        s_rw    <= sh[7];
        s_addr  <= sh[6:0];
        bb_miso <= sh[7] ? smem[sh[6:0]][7] : 1'b0;
      end else if (scnt > 8 && scnt < 16 && s_rw) begin
        bb_miso <= smem[s_addr][15-scnt];
      end
    end
  end

  // ---- helpers ----
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle(output int busy_cyc);
    logic [15:0] s;
    busy_cyc = 0;
    for (int i = 0; i < 10000; i++) begin
      host_read(2'd3, s);
      if (!s[0]) break;
      busy_cyc++;
      @(negedge clk);
    end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    logic [15:0] v;
    host_read(2'd3, v); chk("R1 status", v, 0);
    host_read(2'd2, v); chk("R1 rdata", v, 0);
    chk("R1 csn", bb_csn, 1);
    chk("R1 sclk", bb_sclk, 0);
  endtask

  task automatic t_write();
    logic [15:0] v;
    int bc, f0, r0;
    host_write(2'd1, 16'h77A5);
    host_read(2'd1, v); chk("R4 wdata readback", v, 16'h77A5);
    f0 = frames; r0 = rises;
    host_write(2'd0, 16'h5012);
    host_read(2'd3, v); chk("R5 busy right after accept", v, 1);
    wait_idle(bc);
    chk("R5 busy window", bc, XFER_CYC);
    chk("R2 frame count", frames - f0, 1);
    chk("R2 frame bits", last_frame, {1'b0, 7'h12, 8'hA5});
    chk("R2 chip register", smem[7'h12], 8'hA5);
    chk("R8 rising edges", rises - r0, 16);
    chk("R8 clock period", last_period, 2 * CLK_DIV);
    chk("R8 idle sclk", bb_sclk, 0);
    host_read(2'd2, v); chk("R9 rdata untouched by write", v, 0);
  endtask

  task automatic t_read();
    logic [15:0] v;
    int bc;
    smem[7'h68] = 8'h3C;
    host_write(2'd0, 16'h6068);
    wait_idle(bc);
    chk("R3 busy window", bc, XFER_CYC);
    chk("R3 frame header", last_frame[15:8], {1'b1, 7'h68});
    host_read(2'd2, v); chk("R3 read data", v, 16'h003C);
    smem[7'h00] = 8'hC3;
    host_write(2'd0, 16'h6000);
    wait_idle(bc);
    host_read(2'd2, v); chk("R3 read reg 0", v, 16'h00C3);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    int bc, f0;
    host_write(2'd1, 16'h0011);
    f0 = frames;
    host_write(2'd0, 16'h5005);
    repeat (5) @(negedge clk);
    host_write(2'd0, 16'h6068);
    host_write(2'd0, 16'h5009);
    host_read(2'd0, v); chk("R6 command kept", v, 16'h5005);
    wait_idle(bc);
    repeat (4 * CLK_DIV) @(negedge clk);
    chk("R6 single frame", frames - f0, 1);
    chk("R6 frame intact", last_frame, {1'b0, 7'h05, 8'h11});
    chk("R6 no write to reg 9", smem[7'h09], 8'h00);
    host_read(2'd2, v); chk("R6 rdata unchanged", v, 16'h00C3);
  endtask

  task automatic t_bad_opcode();
    logic [15:0] v;
    int f0;
    f0 = frames;
    host_write(2'd0, 16'h7010);
    host_read(2'd3, v); chk("R7 opcode 7 idle", v, 0);
    host_write(2'd0, 16'h0010);
    host_write(2'd0, 16'h4010);
    host_read(2'd3, v); chk("R7 opcode 4 idle", v, 0);
    repeat (XFER_CYC) @(negedge clk);
    chk("R7 no frame", frames - f0, 0);
    chk("R7 csn high", bb_csn, 1);
  endtask

  task automatic t_addr_top();
    logic [15:0] v;
    int bc;
    host_write(2'd1, 16'h005E);
    host_write(2'd0, 16'h50FF);
    wait_idle(bc);
    chk("R10 reg 0x7F written", smem[7'h7F], 8'h5E);
    chk("R10 frame address", last_frame[14:8], 7'h7F);
    host_write(2'd0, 16'h60FF);
    wait_idle(bc);
    host_read(2'd2, v); chk("R10 reg 0x7F read", v, 16'h005E);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) smem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write();
    t_read();
    t_busy_ignore();
    t_bad_opcode();
    t_addr_top();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule